// File: doc/BRIEF.md
# USB Control Transfer Stage Tracker

This block follows a device-side USB control transfer from stage to stage and raises an interrupt status bit at each stage change that software needs to know about. The packet layer in front of it decodes tokens and handshakes. It passes in one-cycle event strobes: SETUP token, IN token, OUT token, handshake transmitted by the device, handshake received from the host, and protocol error. It also passes two qualifiers taken from the received setup packet: the transfer direction and whether a data stage follows.

The block publishes a 3-bit stage code and five sticky status bits. Each status bit has its own write-one-to-clear strobe and its own enable. A single interrupt line is the OR of the enabled status bits. The setup-complete bit can hold one further event. If a setup completes while that bit is still set, the event is kept and raised again once software clears the bit, so no setup is lost.

Top module: `usb_ctrl_stage_tracker`

## Requirements
- R1: `stage_o` always holds one of seven codes: 000 idle/setup, 001 read data, 010 read status, 011 write data, 100 write status, 101 no-data status, 110 sequence error. Code 111 never appears.
- R2: A SETUP token moves the stage to 000 on the next clock from any stage, including 110. It takes priority over every other event in the same cycle.
- R3: In stage 000, a transmitted handshake (the setup ACK) moves the stage to 001 when a data stage exists and the direction is device-to-host, to 011 when a data stage exists and the direction is host-to-device, and to 101 when no data stage exists. It also sets status bit 0 (setup complete).
- R4: In stage 001, an OUT token moves the stage to 010 and sets status bit 1. An IN token leaves the stage at 001.
- R5: In stage 011, an IN token moves the stage to 100 and sets status bit 2.
- R6: A transmitted handshake in 010, or a received handshake in 100 or 101, moves the stage to 000 and sets status bit 3 (transfer complete).
- R7: A protocol error in any of stages 001 to 101, or an IN token in 010, moves the stage to 110 and sets status bit 4. In 110, only a SETUP token changes the stage.
- R8: If a setup completes while status bit 0 is already set and not being cleared, bit 0 stays set and the event is held. After a clear of bit 0, the bit reads 0 for one cycle and then reads 1 again. A clear with nothing held leaves the bit at 0.
- R9: Each status bit stays set until a 1 is written to its own bit of `irq_clr_i`. A new event in the same cycle as a clear leaves the bit set.
- R10: `irq_o` is high exactly when some status bit is set and its bit of `irq_en_i` is high.
- R11: Reset puts the stage at 000, clears all status bits and drops any held setup-complete event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| setup_tok_i | input | 1 | SETUP token strobe |
| in_tok_i | input | 1 | IN token strobe |
| out_tok_i | input | 1 | OUT token strobe |
| ack_tx_i | input | 1 | Handshake ACK transmitted by the device |
| ack_rx_i | input | 1 | Handshake ACK received from the host |
| err_i | input | 1 | Protocol error strobe |
| dir_in_i | input | 1 | 1: data flows device-to-host (read) |
| has_data_i | input | 1 | 1: the transfer has a data stage |
| irq_clr_i | input | 5 | Write-one-to-clear strobes, one per status bit |
| irq_en_i | input | 5 | Enable per status bit for `irq_o` |
| stage_o | output | 3 | Current stage code |
| irq_status_o | output | 5 | Sticky status: 0 setup done, 1 read status, 2 write status, 3 complete, 4 sequence error |
| irq_o | output | 1 | OR of enabled status bits |

## Verification
The bench builds the block with the default `SETUP_HOLD = 1`. With that value the held setup-complete path is present, so a second setup completed over an uncleared bit can be observed as the bit falling for one cycle and rising again after a clear. The directed scenarios cover read, write and no-data transfers, a sequence error from an unexpected IN token and from a protocol error, a SETUP token that aborts a transfer midway, and the enable mask on the combined interrupt line.

// File: rtl/ctl_stage_pkg.sv
package ctl_stage_pkg;
  localparam int STAGE_W = 3;
  localparam int NUM_IRQ = 5;

  localparam int IRQ_SETUP  = 0;
  localparam int IRQ_RD_ST  = 1;
  localparam int IRQ_WR_ST  = 2;
  localparam int IRQ_DONE   = 3;
  localparam int IRQ_SEQERR = 4;

  typedef enum logic [STAGE_W-1:0] {
    ST_IDLE   = 3'b000,
    ST_RD_DAT = 3'b001,
    ST_RD_STS = 3'b010,
    ST_WR_DAT = 3'b011,
    ST_WR_STS = 3'b100,
    ST_ND_STS = 3'b101,
    ST_SEQERR = 3'b110
  } stage_e;

  typedef struct packed {
    logic setup;
    logic in_tok;
    logic out_tok;
    logic ack_tx;
    logic ack_rx;
    logic err;
  } pkt_ev_t;
endpackage

// File: rtl/ctl_stage_fsm.sv
module ctl_stage_fsm
  import ctl_stage_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  pkt_ev_t            ev_i,
  input  logic               dir_in_i,
  input  logic               has_data_i,
  output stage_e             stage_o,
  output logic [NUM_IRQ-1:0] evt_o
);
  stage_e stage_q, stage_d;

  always_comb begin
    stage_d = stage_q;
    evt_o   = '0;
    if (ev_i.setup) begin
      stage_d = ST_IDLE;
    end else begin
      unique case (stage_q)
        ST_IDLE: if (ev_i.ack_tx) begin
          evt_o[IRQ_SETUP] = 1'b1;
          if (!has_data_i)   stage_d = ST_ND_STS;
          else if (dir_in_i) stage_d = ST_RD_DAT;
          else               stage_d = ST_WR_DAT;
        end
        ST_RD_DAT: begin
          if (ev_i.err) begin
            stage_d = ST_SEQERR;
            evt_o[IRQ_SEQERR] = 1'b1;
          end else if (ev_i.out_tok) begin
            stage_d = ST_RD_STS;
            evt_o[IRQ_RD_ST] = 1'b1;
          end
        end
        ST_RD_STS: begin
          // IN token is not legal once the read status stage begins
          if (ev_i.err || ev_i.in_tok) begin
            stage_d = ST_SEQERR;
            evt_o[IRQ_SEQERR] = 1'b1;
          end else if (ev_i.ack_tx) begin
            stage_d = ST_IDLE;
            evt_o[IRQ_DONE] = 1'b1;
          end
        end
        ST_WR_DAT: begin
          if (ev_i.err) begin
            stage_d = ST_SEQERR;
            evt_o[IRQ_SEQERR] = 1'b1;
          end else if (ev_i.in_tok) begin
            stage_d = ST_WR_STS;
            evt_o[IRQ_WR_ST] = 1'b1;
          end
        end
        ST_WR_STS, ST_ND_STS: begin
          if (ev_i.err) begin
            stage_d = ST_SEQERR;
            evt_o[IRQ_SEQERR] = 1'b1;
          end else if (ev_i.ack_rx) begin
            stage_d = ST_IDLE;
            evt_o[IRQ_DONE] = 1'b1;
          end
        end
        ST_SEQERR: stage_d = ST_SEQERR;
        default:   stage_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= ST_IDLE;
    else         stage_q <= stage_d;
  end

  assign stage_o = stage_q;
endmodule

// File: rtl/ctl_irq_bit.sv
module ctl_irq_bit #(
  parameter bit HOLD = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic sts_o
);
  logic sts_q, pend_q, release_w;

  generate
    if (HOLD) begin : g_hold
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                         pend_q <= 1'b0;
        else if (set_i && sts_q && !clr_i)   pend_q <= 1'b1;
        else if (pend_q && !sts_q)           pend_q <= 1'b0;
      end
    end else begin : g_plain
      assign pend_q = 1'b0;
    end
  endgenerate

  assign release_w = pend_q & ~sts_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_q <= 1'b0;
    else         sts_q <= set_i | release_w | (sts_q & ~clr_i);
  end

  assign sts_o = sts_q;
endmodule

// File: rtl/ctl_irq_status.sv
module ctl_irq_status
  import ctl_stage_pkg::*;
#(
  parameter bit SETUP_HOLD = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] evt_i,
  input  logic [NUM_IRQ-1:0] clr_i,
  input  logic [NUM_IRQ-1:0] en_i,
  output logic [NUM_IRQ-1:0] sts_o,
  output logic               irq_o
);
  generate
    for (genvar k = 0; k < NUM_IRQ; k++) begin : g_bit
      ctl_irq_bit #(
        .HOLD ((k == IRQ_SETUP) && SETUP_HOLD)
      ) u_bit (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .set_i (evt_i[k]),
        .clr_i (clr_i[k]),
        .sts_o (sts_o[k])
      );
    end
  endgenerate

  assign irq_o = |(sts_o & en_i);
endmodule

// File: rtl/usb_ctrl_stage_tracker.sv
module usb_ctrl_stage_tracker
  import ctl_stage_pkg::*;
#(
  parameter bit SETUP_HOLD = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               setup_tok_i,
  input  logic               in_tok_i,
  input  logic               out_tok_i,
  input  logic               ack_tx_i,
  input  logic               ack_rx_i,
  input  logic               err_i,
  input  logic               dir_in_i,
  input  logic               has_data_i,
  input  logic [NUM_IRQ-1:0] irq_clr_i,
  input  logic [NUM_IRQ-1:0] irq_en_i,
  output logic [STAGE_W-1:0] stage_o,
  output logic [NUM_IRQ-1:0] irq_status_o,
  output logic               irq_o
);
  pkt_ev_t            ev;
  stage_e             stage;
  logic [NUM_IRQ-1:0] evt;

  assign ev = '{setup: setup_tok_i, in_tok: in_tok_i, out_tok: out_tok_i,
                ack_tx: ack_tx_i, ack_rx: ack_rx_i, err: err_i};

  ctl_stage_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ev_i      (ev),
    .dir_in_i  (dir_in_i),
    .has_data_i(has_data_i),
    .stage_o   (stage),
    .evt_o     (evt)
  );

  ctl_irq_status #(.SETUP_HOLD(SETUP_HOLD)) u_sts (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .evt_i (evt),
    .clr_i (irq_clr_i),
    .en_i  (irq_en_i),
    .sts_o (irq_status_o),
    .irq_o (irq_o)
  );

  assign stage_o = stage;
endmodule

// File: rtl/ctl_stage_chk.sv
module ctl_stage_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       setup_tok_i,
  input logic       in_tok_i,
  input logic       out_tok_i,
  input logic       ack_tx_i,
  input logic       ack_rx_i,
  input logic       err_i,
  input logic       dir_in_i,
  input logic       has_data_i,
  input logic [4:0] irq_clr_i,
  input logic [4:0] irq_en_i,
  input logic [2:0] stage_o,
  input logic [4:0] irq_status_o,
  input logic       irq_o
);
  a_r1_code_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stage_o != 3'b111);

  a_r2_setup_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    setup_tok_i |=> stage_o == 3'b000);

  a_r4_read_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stage_o == 3'b001 && out_tok_i && !err_i && !setup_tok_i)
      |=> (stage_o == 3'b010 && irq_status_o[1]));

  a_r6_read_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stage_o == 3'b010 && ack_tx_i && !err_i && !in_tok_i && !setup_tok_i)
      |=> (stage_o == 3'b000 && irq_status_o[3]));

  a_r7_seqerr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stage_o == 3'b110 && !setup_tok_i) |=> stage_o == 3'b110);

  a_r9_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_status_o != 5'b0) |=>
      (($past(irq_status_o) & ~$past(irq_clr_i) & ~irq_status_o) == 5'b0));

  a_r10_irq_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((irq_status_o & irq_en_i) == 5'b0) |-> !irq_o);

  // unused qualifiers kept on the port list so the bind maps every top port
  logic unused_w;
  assign unused_w = ack_rx_i ^ dir_in_i ^ has_data_i;
endmodule

bind usb_ctrl_stage_tracker ctl_stage_chk chk_i (.*);

// File: tb/usb_ctrl_stage_tracker_tb_top.sv
module usb_ctrl_stage_tracker_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic setup_tok = 0, in_tok = 0, out_tok = 0, ack_tx = 0, ack_rx = 0, err = 0;
  logic dir_in = 0, has_data = 0;
  logic [4:0] irq_clr = '0, irq_en = '0;
  logic [2:0] stage;
  logic [4:0] sts;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_ctrl_stage_tracker dut_i (
    .clk_i(clk), .rst_ni(rst_n), .setup_tok_i(setup_tok), .in_tok_i(in_tok),
    .out_tok_i(out_tok), .ack_tx_i(ack_tx), .ack_rx_i(ack_rx), .err_i(err),
    .dir_in_i(dir_in), .has_data_i(has_data), .irq_clr_i(irq_clr),
    .irq_en_i(irq_en), .stage_o(stage), .irq_status_o(sts), .irq_o(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // v = {err, ack_rx, ack_tx, out, in, setup}; held for one clock, sampled at next negedge
  task automatic ev(input logic [5:0] v);
    {err, ack_rx, ack_tx, out_tok, in_tok, setup_tok} = v;
    @(negedge clk);
    {err, ack_rx, ack_tx, out_tok, in_tok, setup_tok} = '0;
  endtask

  task automatic clr(input logic [4:0] m);
    irq_clr = m;
    @(negedge clk);
    irq_clr = '0;
  endtask

  localparam logic [5:0] E_SETUP = 6'b000001, E_IN = 6'b000010, E_OUT = 6'b000100,
                         E_ATX = 6'b001000, E_ARX = 6'b010000, E_ERR = 6'b100000;

  task automatic t_reset;
    chk("R11 stage", stage, 0);
    chk("R11 status", sts, 0);
    chk("R10 irq idle", irq, 0);
  endtask

  task automatic t_read;
    dir_in = 1; has_data = 1;
    ev(E_SETUP); chk("R2 setup", stage, 0);
    ev(E_ATX);   chk("R3 read data", stage, 1); chk("R3 bit0", sts[0], 1);
    ev(E_IN);    chk("R4 IN keeps 001", stage, 1);
    ev(E_OUT);   chk("R4 read status", stage, 2); chk("R4 bit1", sts[1], 1);
    ev(E_ATX);   chk("R6 read done", stage, 0); chk("R6 bit3", sts[3], 1);
    chk("R9 bits stay", sts, 5'b01011);
    clr(5'b01011); chk("R9 cleared", sts, 0);
  endtask

  task automatic t_write;
    dir_in = 0; has_data = 1;
    ev(E_SETUP); ev(E_ATX); chk("R3 write data", stage, 3);
    ev(E_IN);    chk("R5 write status", stage, 4); chk("R5 bit2", sts[2], 1);
    ev(E_ATX);   chk("R6 wrong ack ignored", stage, 4);
    ev(E_ARX);   chk("R6 write done", stage, 0); chk("R6 bit3", sts[3], 1);
    clr(5'b11111);
  endtask

  task automatic t_nodata;
    has_data = 0;
    ev(E_SETUP); ev(E_ATX); chk("R3 no-data status", stage, 5);
    ev(E_ARX);   chk("R6 no-data done", stage, 0); chk("R6 bit3 nd", sts[3], 1);
    clr(5'b11111);
  endtask

  task automatic t_seqerr;
    dir_in = 1; has_data = 1;
    ev(E_SETUP); ev(E_ATX); ev(E_OUT);
    ev(E_IN);    chk("R7 IN in 010", stage, 6); chk("R7 bit4", sts[4], 1);
    ev(E_ATX | E_ARX | E_OUT | E_IN); chk("R7 hold 110", stage, 6);
    ev(E_SETUP | E_ERR); chk("R2 setup beats err", stage, 0);
    dir_in = 0;
    clr(5'b11111);
    ev(E_ATX); ev(E_ERR); chk("R7 err in 011", stage, 6); chk("R7 bit4 err", sts[4], 1);
    ev(E_SETUP); clr(5'b11111);
  endtask

  task automatic t_abort;
    dir_in = 0; has_data = 1;
    ev(E_SETUP); ev(E_ATX); ev(E_IN);
    ev(E_SETUP); chk("R2 abort from 100", stage, 0);
    chk("R2 no done bit", sts[3], 0);
    clr(5'b11111);
  endtask

  task automatic t_pending;
    has_data = 0;
    ev(E_SETUP); ev(E_ATX); chk("R8 first", sts[0], 1);
    ev(E_SETUP); ev(E_ATX); chk("R8 still set", sts[0], 1);
    clr(5'b00001); chk("R8 low one cycle", sts[0], 0);
    @(negedge clk); chk("R8 reasserted", sts[0], 1);
    clr(5'b00001); @(negedge clk); chk("R8 nothing held", sts[0], 0);
    ev(E_SETUP); ev(E_ATX);
    irq_clr = 5'b00001; ack_rx = 1; // completion with clear of bit 0 same cycle
    @(negedge clk); irq_clr = 0; ack_rx = 0;
    chk("R9 clear clears bit0", sts[0], 0);
    chk("R9 set beats nothing", sts[3], 1);
    clr(5'b11111);
  endtask

  task automatic t_mask;
    has_data = 0;
    ev(E_SETUP); ev(E_ATX);
    irq_en = 5'b11110; #1; chk("R10 masked", irq, 0);
    irq_en = 5'b00001; #1; chk("R10 enabled", irq, 1);
    ev(E_ARX); irq_en = 5'b01000; clr(5'b00001); chk("R10 bit3 only", irq, 1);
    irq_en = 0;
  endtask

  task automatic t_midreset;
    dir_in = 1; has_data = 1;
    ev(E_SETUP); ev(E_ATX);
    ev(E_ATX); ev(E_SETUP); ev(E_ATX); // second setup over set bit0 -> held
    rst_n = 0; #1;
    chk("R11 stage", stage, 0); chk("R11 status", sts, 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk); @(negedge clk);
    chk("R11 held dropped", sts[0], 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_read();
    t_write();
    t_nodata();
    t_seqerr();
    t_abort();
    t_pending();
    t_mask();
    t_midreset();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule